// File: doc/BRIEF.md
# Link Power State Controller

This block sequences a serial link through four graded power levels. In the full-power level, payload data moves and the forwarded clock runs. In the shallow level, only data stops. In the middle level, data and the forwarded clock stop and the clock-sourcing end keeps its PLL running. In the deepest level, the PLL is powered down as well. The block drives three enables: data, forwarded clock (on the receiving end this gates the clock receiver), and PLL. It changes them in a safe order, with a programmable number of cycles between steps.

Level requests come from hardware activity logic or from a software register. A software request wins over a hardware request in the same cycle. Every exit goes back to full power. A move between two low-power levels passes through full power first. The same RTL serves both ends of the link, and a role input selects the end. The block reports its current level and a busy flag.

Top module: `link_pwr_ctrl`

## Requirements
- R1: After reset, `lvl` is 0, `data_en`, `fclk_en` and `pll_en` are all 1, and `busy` is 0.
- R2: `lvl` encodes the settled level as 0 = full power, 1 = data off, 2 = data and clock off, 3 = deep. When `busy` is 0, the enables match that level: level 0 has all three on, level 1 has only `data_en` off, level 2 has data and clock off, and level 3 has all three off (except as R4 states for level 2).
- R3: Entry from level 0 clears `data_en` on the edge that accepts the request. For level 2 or 3, `fclk_en` clears `gap`+1 edges later. Entry to level 1 completes on the accepting edge, and `busy` never rises for it.
- R4: `pll_en` clears `gap`+1 edges after `fclk_en` when the target is level 3. It also clears when the target is level 2 and `src_role` is 0. On a clock-sourcing end (`src_role` = 1), level 2 keeps `pll_en` at 1.
- R5: On exit to level 0 with the PLL off, `pll_en` sets on the accepting edge. `fclk_en` sets on the first edge that samples `pll_locked` high, and `data_en` sets `gap`+1 edges after that. With the PLL already on, `fclk_en` sets on the accepting edge. From level 1, `data_en` sets on the accepting edge.
- R6: When `sw_req` and `hw_req` are both high in one cycle, the software target level is the one carried out.
- R7: Requests that arrive while `busy` is 1 are ignored, with no queuing. A request for the current level is ignored.
- R8: A request from one low-power level to another first completes the exit to level 0, with `lvl` reading 0 for one cycle. It then starts the entry on the next edge.
- R9: `busy` is 1 from the accepting edge of a multi-step transition until the edge that completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_role | input | 1 | 1 = clock-sourcing end, 0 = clock-receiving end |
| gap | input | GAP_W | Wait, in cycles minus one, between enable steps |
| hw_req | input | 1 | Hardware level request strobe |
| hw_lvl | input | 2 | Hardware requested level |
| sw_req | input | 1 | Software level request strobe |
| sw_lvl | input | 2 | Software requested level |
| pll_locked | input | 1 | PLL lock indication |
| data_en | output | 1 | Data transmission enable |
| fclk_en | output | 1 | Forwarded clock driver / receiver enable |
| pll_en | output | 1 | PLL power enable |
| lvl | output | 2 | Current settled level |
| busy | output | 1 | Transition in progress |

## Verification
Each result has a fixed edge count after the accepting edge: edge 0 for the first enable, then edge `gap`+1 and edge 2·(`gap`+1) for the later steps. On exit, the count runs from the edge that samples lock. With `gap` = 3, the bench sets inputs at the falling edge and advances an exact number of rising edges before sampling at the next falling edge. It samples one edge before each step as well as at the step, so a step that arrives one cycle early or late is seen.

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_role,
  input  logic [GAP_W-1:0] gap,
  input  logic             hw_req,
  input  logic [1:0]       hw_lvl,
  input  logic             sw_req,
  input  logic [1:0]       sw_lvl,
  input  logic             pll_locked,
  output logic             data_en,
  output logic             fclk_en,
  output logic             pll_en,
  output logic [1:0]       lvl,
  output logic             busy
);
  typedef enum logic [2:0] {S_IDLE, S_DN_CLK, S_DN_PLL, S_UP_LOCK, S_UP_DATA} seq_t;

  seq_t             seq;
  logic [GAP_W-1:0] cnt;
  logic [1:0]       tgt, pend_lvl;
  logic             pend;

  wire       req_v   = pend | sw_req | hw_req;
  wire [1:0] req_l   = pend ? pend_lvl : (sw_req ? sw_lvl : hw_lvl);
  wire       pll_off = (tgt == 2'd3) || (tgt == 2'd2 && !src_role);
  wire       cnt_end = (cnt == gap);

  assign busy = (seq != S_IDLE) || pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq <= S_IDLE; cnt <= '0; tgt <= '0; lvl <= '0;
      pend <= 1'b0; pend_lvl <= '0;
      data_en <= 1'b1; fclk_en <= 1'b1; pll_en <= 1'b1;
    end else begin
      case (seq)
        S_IDLE: if (req_v && req_l != lvl) begin
          if (lvl == 2'd0) begin
            data_en <= 1'b0;
            tgt     <= req_l;
            pend    <= 1'b0;
            if (req_l == 2'd1) lvl <= 2'd1;
            else begin cnt <= '0; seq <= S_DN_CLK; end
          end else begin
            if (req_l != 2'd0) begin pend <= 1'b1; pend_lvl <= req_l; end
            if (!pll_en) begin
              pll_en <= 1'b1; seq <= S_UP_LOCK;
            end else if (!fclk_en) begin
              fclk_en <= 1'b1; cnt <= '0; seq <= S_UP_DATA;
            end else begin
              data_en <= 1'b1; lvl <= 2'd0;
            end
          end
        end
        S_DN_CLK: if (cnt_end) begin
          fclk_en <= 1'b0; cnt <= '0;
          if (pll_off) seq <= S_DN_PLL;
          else begin lvl <= tgt; seq <= S_IDLE; end
        end else cnt <= cnt + 1'b1;
        S_DN_PLL: if (cnt_end) begin
          pll_en <= 1'b0; lvl <= tgt; seq <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_UP_LOCK: if (pll_locked) begin
          fclk_en <= 1'b1; cnt <= '0; seq <= S_UP_DATA;
        end
        S_UP_DATA: if (cnt_end) begin
          data_en <= 1'b1; lvl <= 2'd0; seq <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: seq <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_pwr_ctrl_chk.sv
module link_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       src_role,
  input logic       data_en,
  input logic       fclk_en,
  input logic       pll_en,
  input logic [1:0] lvl,
  input logic       busy
);
  AST_DATA_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n) data_en |-> fclk_en);            // R3
  AST_CLK_NEEDS_PLL:  assert property (@(posedge clk) disable iff (!rst_n) fclk_en |-> pll_en);             // R5
  AST_LVL0_ALL_ON:    assert property (@(posedge clk) disable iff (!rst_n)
                        (!busy && lvl == 2'd0) |-> (data_en && fclk_en && pll_en));                         // R2
  AST_LVL1_CLK_ONLY:  assert property (@(posedge clk) disable iff (!rst_n)
                        (!busy && lvl == 2'd1) |-> (!data_en && fclk_en && pll_en));                        // R2
  AST_LVL3_ALL_OFF:   assert property (@(posedge clk) disable iff (!rst_n)
                        (!busy && lvl == 2'd3) |-> (!data_en && !fclk_en && !pll_en));                      // R4
  AST_SRC_KEEPS_PLL:  assert property (@(posedge clk) disable iff (!rst_n)
                        (!busy && lvl == 2'd2 && src_role) |-> pll_en);                                     // R4
  AST_PLL_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n) $rose(pll_en) |-> !fclk_en);     // R5
endmodule

bind link_pwr_ctrl link_pwr_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .src_role(src_role), .data_en(data_en),
  .fclk_en(fclk_en), .pll_en(pll_en), .lvl(lvl), .busy(busy)
);

// File: tb/test_link_pwr_ctrl.sv
module test_link_pwr_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, src_role = 1'b1;
  logic [7:0] gap = 8'd3;
  logic hw_req = 1'b0, sw_req = 1'b0, pll_locked = 1'b1;
  logic [1:0] hw_lvl = '0, sw_lvl = '0;
  logic data_en, fclk_en, pll_en, busy;
  logic [1:0] lvl;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  link_pwr_ctrl #(.GAP_W(8)) i_link_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .src_role(src_role), .gap(gap),
    .hw_req(hw_req), .hw_lvl(hw_lvl), .sw_req(sw_req), .sw_lvl(sw_lvl),
    .pll_locked(pll_locked), .data_en(data_en), .fclk_en(fclk_en),
    .pll_en(pll_en), .lvl(lvl), .busy(busy)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic state(string tag, int l, int d, int c, int p, int b);
    chk({tag, " lvl"}, lvl, l);
    chk({tag, " data_en"}, data_en, d);
    chk({tag, " fclk_en"}, fclk_en, c);
    chk({tag, " pll_en"}, pll_en, p);
    chk({tag, " busy"}, busy, b);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic request(bit sw, bit hw, int swl, int hwl);
    sw_req = sw; sw_lvl = swl[1:0]; hw_req = hw; hw_lvl = hwl[1:0];
    step(1);
    sw_req = 0; hw_req = 0;
  endtask

  task automatic t_reset();
    state("R1 reset", 0, 1, 1, 1, 0);
  endtask

  task automatic t_shallow();
    request(0, 1, 0, 1);
    state("R3 enter lvl1", 1, 0, 1, 1, 0);
    request(1, 0, 0, 0);
    state("R5 exit lvl1", 0, 1, 1, 1, 0);
    request(1, 0, 0, 0);
    state("R7 same level ignored", 0, 1, 1, 1, 0);
  endtask

  task automatic t_src_lvl2();
    request(0, 1, 0, 2);
    state("R9 lvl2 data step", 0, 0, 1, 1, 1);
    step(3);
    state("R3 lvl2 before clk step", 0, 0, 1, 1, 1);
    step(1);
    state("R4 lvl2 src settled", 2, 0, 0, 1, 0);
  endtask

  task automatic t_lvl2_to_lvl1();
    request(1, 0, 1, 0);
    state("R5 clk on at accept", 2, 0, 1, 1, 1);
    step(3);
    state("R8 via lvl0 pre", 2, 0, 1, 1, 1);
    step(1);
    state("R8 passes lvl0", 0, 1, 1, 1, 1);
    step(1);
    state("R8 lands lvl1", 1, 0, 1, 1, 0);
    request(1, 0, 0, 0);
    state("R2 back lvl0", 0, 1, 1, 1, 0);
  endtask

  task automatic t_deep_busy_ignore();
    request(1, 0, 3, 0);
    sw_req = 1; sw_lvl = 2'd1;
    step(1);
    sw_req = 0;
    step(6);
    state("R4 deep before pll step", 0, 0, 0, 1, 1);
    step(1);
    state("R7 busy req ignored deep", 3, 0, 0, 0, 0);
  endtask

  task automatic t_deep_exit();
    pll_locked = 0;
    request(1, 0, 0, 0);
    state("R5 pll on first", 3, 0, 0, 1, 1);
    step(5);
    state("R5 waits lock", 3, 0, 0, 1, 1);
    pll_locked = 1;
    step(1);
    state("R5 clk after lock", 3, 0, 1, 1, 1);
    step(3);
    chk("R5 data before gap", data_en, 0);
    step(1);
    state("R5 deep exit done", 0, 1, 1, 1, 0);
  endtask

  task automatic t_priority();
    request(1, 1, 2, 1);
    step(4);
    state("R6 sw wins", 2, 0, 0, 1, 0);
    request(1, 0, 0, 0);
    step(4);
    state("R6 restore", 0, 1, 1, 1, 0);
  endtask

  task automatic t_receiver();
    src_role = 0;
    request(0, 1, 0, 2);
    step(7);
    state("R4 rx before pll off", 0, 0, 0, 1, 1);
    step(1);
    state("R4 rx lvl2 pll off", 2, 0, 0, 0, 0);
    request(0, 1, 0, 0);
    step(1);
    chk("R5 rx clk after lock", fclk_en, 1);
    step(4);
    state("R5 rx back lvl0", 0, 1, 1, 1, 0);
    src_role = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_shallow();
    t_src_lvl2();
    t_lvl2_to_lvl1();
    t_deep_busy_ignore();
    t_deep_exit();
    t_priority();
    t_receiver();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule